// File: doc/BRIEF.md
# Serial Port with Flag-Tagged Receive Queue

This block is an asynchronous serial transmitter and receiver behind a small register interface. A write to the data register queues one byte for sending. A read of the data register takes one received character off the queue. That character comes with its own error flags: overrun, break, parity error and framing error. A second register address lets software look at those flags for the character at the head of the queue without removing it. Bit timing comes from a tick input that pulses sixteen times per bit period. Parity can be turned on, and can be set to even or odd.

With queue mode on, each direction has a 16-entry FIFO. With queue mode off, each direction holds a single word. When a character arrives and the receive side has no room, the character is dropped. The newest stored entry is then marked as overrun. The next character that finds room is stored unmarked.

The transmitter state machine has five states. TX_IDLE goes to TX_START when the queue is not empty, and the head word is popped on that transition. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_PARITY after the eighth bit when parity is on, and to TX_STOP otherwise. TX_PARITY goes to TX_STOP. TX_STOP goes back to TX_IDLE.

The receiver state machine has six states. RX_IDLE goes to RX_START on a low line. RX_START goes to RX_DATA if the line is still low at half a bit, and back to RX_IDLE if it is not. RX_DATA goes to RX_PARITY or RX_STOP after eight bits. RX_PARITY goes to RX_STOP. RX_STOP stores the entry. It then goes to RX_IDLE if the stop bit was high, or to RX_WAIT_HIGH if it was low. RX_WAIT_HIGH goes to RX_IDLE once the line is high again.

Top module: `uart_tag_top`

## Requirements
- R1: After reset `txd` is high, and reads of both addresses return zero.
- R2: Each transmitted character is sent in this order: a low start bit, eight data bits LSB first, a parity bit only when `par_en` is set, and a high stop bit. Every bit lasts 16 ticks.
- R3: The parity bit makes the count of ones across the data and the parity bit even when `par_odd` is 0, and odd when `par_odd` is 1.
- R4: With `fifo_en` set, written bytes are sent in write order. The transmit queue holds 16 entries, and a write that finds it full is discarded.
- R5: With `fifo_en` clear, the transmit side holds one word. A write while that word is occupied is discarded.
- R6: A read of address 0 returns {20'b0, overrun(bit 11), break(bit 10), parity error(bit 9), framing error(bit 8), data(bits 7:0)} for the head entry and removes that entry. A read of an empty queue returns zero.
- R7: A read of address 1 returns {28'b0, overrun(bit 3), break(bit 2), parity error(bit 1), framing error(bit 0)} of the head entry and does not remove it.
- R8: When parity is enabled, a received parity bit that does not match the selected parity sets the parity error flag.
- R9: A stop bit sampled low sets the framing error flag. The receiver then waits for the line to go high before it accepts a new start bit.
- R10: A character whose every bit is low, including parity and stop, is stored with data 0, break and framing set, and parity error clear.
- R11: The receiver samples each bit at mid-bit. A start bit that is no longer low half a bit after the falling edge is discarded and stores nothing.
- R12: A character that arrives when the receive side is full is dropped, and the newest stored entry gets its overrun flag set. The next character that is stored has overrun clear. The receive side holds 16 entries with `fifo_en` set and 1 entry with it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| fifo_en | input | 1 | 1: 16-entry queues, 0: single word per direction |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0: data register, 1: receive status |
| wdata | input | 8 | Byte to transmit |
| rdata | output | 32 | Read value for `addr` |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The bench goes after the overrun boundary. It fills all sixteen entries and then sends a seventeenth character, which should be lost while the sixteenth entry gets marked. A design that overwrote an entry, marked the wrong entry, or left the mark on the next stored character would show a wrong byte or a wrong bit 11. The single-word modes are run in both directions: a design that kept queueing there would send or return an extra character. Other cases are a short start glitch (a weak start check would produce a spurious entry), a full-low frame (the break and framing bits would be missing or data nonzero), and a bad stop bit followed by a slow line release (a receiver that re-armed at once would store a phantom character).

// File: rtl/uart_tag_pkg.sv
package uart_tag_pkg;

    typedef struct packed {
        logic       ovr;
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_WAIT_HIGH
    } rx_state_t;

endpackage

// File: rtl/uart_tag_fifo.sv
module uart_tag_fifo #(
    parameter int W        = 8,
    parameter int DEPTH    = 16,
    parameter int MARK_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         single,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         mark,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, tail_ptr;
    logic [CW-1:0] count;

    assign tail_ptr = wr_ptr - 1'b1;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
        if (mark) mem[tail_ptr][MARK_BIT] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = single ? (count >= CW'(1)) : (count >= CW'(DEPTH));

    p_push_room_r12: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    p_pop_filled_r6: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
    p_mark_target_r12: assert property (@(posedge clk) disable iff (!rst_n) mark |-> !empty);
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH));

endmodule

// File: rtl/uart_tag_tx.sv
module uart_tag_tx
    import uart_tag_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       have_data,
    input  logic [7:0] din,
    output logic       pop,
    output logic       txd
);
    localparam int CNTW = $clog2(OVS);
    localparam logic [CNTW-1:0] LAST = CNTW'(OVS - 1);

    tx_state_t       st, nxt;
    logic [CNTW-1:0] cnt;
    logic [2:0]      bitn;
    logic [7:0]      shreg;
    logic            pbit;
    logic            bit_end;

    assign bit_end = tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            TX_IDLE:   if (have_data) nxt = TX_START;
            TX_START:  if (bit_end) nxt = TX_DATA;
            TX_DATA:   if (bit_end && bitn == 3'd7) nxt = par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) nxt = TX_STOP;
            TX_STOP:   if (bit_end) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else if (st == TX_IDLE) begin
            cnt  <= '0;
            bitn <= '0;
            if (have_data) begin
                shreg <= din;
                pbit  <= par_odd ? ~^din : ^din;
            end
        end else if (tick) begin
            if (cnt == LAST) begin
                cnt <= '0;
                if (st == TX_DATA) begin
                    shreg <= shreg >> 1;
                    bitn  <= bitn + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        pop = (st == TX_IDLE) && have_data;
        unique case (st)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = pbit;
            default:   txd = 1'b1;
        endcase
    end

    p_line_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != TX_IDLE && !tick) |=> $stable(txd));
    p_pop_starts_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (st == TX_START));

endmodule

// File: rtl/uart_tag_rx.sv
module uart_tag_rx
    import uart_tag_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      rxd,
    output logic      valid,
    output rx_entry_t entry
);
    localparam int CNTW = $clog2(OVS);
    localparam logic [CNTW-1:0] LAST = CNTW'(OVS - 1);
    localparam logic [CNTW-1:0] MID  = CNTW'(OVS / 2 - 1);

    rx_state_t       st, nxt;
    logic            sync1, rx_s;
    logic [CNTW-1:0] cnt;
    logic [2:0]      bitn;
    logic [7:0]      shreg;
    logic            pbit;
    logic            mid_pt, exp_par, all_low;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            rx_s  <= 1'b1;
        end else begin
            sync1 <= rxd;
            rx_s  <= sync1;
        end
    end

    assign mid_pt  = tick && ((st == RX_START) ? (cnt == MID) : (cnt == LAST));
    assign exp_par = par_odd ? ~^shreg : ^shreg;
    assign all_low = (shreg == 8'd0) && !rx_s && (!par_en || !pbit);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            RX_IDLE:      if (tick && !rx_s) nxt = RX_START;
            RX_START:     if (mid_pt) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:      if (mid_pt && bitn == 3'd7) nxt = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY:    if (mid_pt) nxt = RX_STOP;
            RX_STOP:      if (mid_pt) nxt = rx_s ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (rx_s) nxt = RX_IDLE;
            default:      nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            valid <= 1'b0;
            entry <= '0;
        end else begin
            valid <= 1'b0;
            if (st == RX_IDLE || st == RX_WAIT_HIGH) begin
                cnt  <= '0;
                bitn <= '0;
            end else if (tick) begin
                if (mid_pt) begin
                    cnt <= '0;
                    unique case (st)
                        RX_DATA: begin
                            shreg <= {rx_s, shreg[7:1]};
                            bitn  <= bitn + 1'b1;
                        end
                        RX_PARITY: pbit <= rx_s;
                        RX_STOP: begin
                            valid      <= 1'b1;
                            entry.ovr  <= 1'b0;
                            entry.frm  <= !rx_s;
                            entry.brk  <= all_low;
                            entry.par  <= !all_low && par_en && (pbit != exp_par);
                            entry.data <= shreg;
                        end
                        default: ;
                    endcase
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_single_store_r6: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);
    p_store_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(st) == RX_STOP);
    p_break_has_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && entry.brk) |-> (entry.data == 8'd0 && entry.frm && !entry.par));

endmodule

// File: rtl/uart_tag_top.sv
module uart_tag_top
    import uart_tag_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick16,
    input  logic        fifo_en,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        addr,
    input  logic [7:0]  wdata,
    output logic [31:0] rdata,
    input  logic        rxd,
    output logic        txd
);
    localparam int OVR_BIT = ENTRY_W - 1;

    logic       tx_push, tx_pop, tx_empty, tx_full;
    logic [7:0] tx_head;
    logic       rx_valid, rx_push, rx_pop, rx_mark, rx_empty, rx_full;
    rx_entry_t  rx_new;
    logic [ENTRY_W-1:0] rx_head;

    assign tx_push = wr_en && !addr && !tx_full;
    assign rx_pop  = rd_en && !addr && !rx_empty;
    assign rx_push = rx_valid && !rx_full;
    assign rx_mark = rx_valid && rx_full;

    uart_tag_fifo #(.W(8), .DEPTH(DEPTH), .MARK_BIT(7)) u_txq (
        .clk(clk), .rst_n(rst_n), .single(!fifo_en),
        .push(tx_push), .din(wdata), .pop(tx_pop), .mark(1'b0),
        .dout(tx_head), .empty(tx_empty), .full(tx_full)
    );

    uart_tag_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .par_en(par_en), .par_odd(par_odd),
        .have_data(!tx_empty), .din(tx_head), .pop(tx_pop), .txd(txd)
    );

    uart_tag_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
        .valid(rx_valid), .entry(rx_new)
    );

    uart_tag_fifo #(.W(ENTRY_W), .DEPTH(DEPTH), .MARK_BIT(OVR_BIT)) u_rxq (
        .clk(clk), .rst_n(rst_n), .single(!fifo_en),
        .push(rx_push), .din(rx_new), .pop(rx_pop), .mark(rx_mark),
        .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    always_comb begin
        rdata = '0;
        if (!rx_empty) begin
            if (addr) rdata = {28'd0, rx_head[ENTRY_W-1:8]};
            else      rdata = {{(32-ENTRY_W){1'b0}}, rx_head};
        end
    end

    p_drop_keeps_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full && !rx_pop) |=> rx_full);
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && !tx_full) |=> !tx_empty);

endmodule

// File: tb/uart_tag_top_test.sv
module uart_tag_top_test;
    localparam int BIT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b0;
    logic        fifo_en = 1'b1, par_en = 1'b0, par_odd = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [31:0] rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int total = 0;
    int bad = 0;
    bit reported = 0;

    uart_tag_top uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .fifo_en(fifo_en),
        .par_en(par_en), .par_odd(par_odd), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd)
    );

    always #4 clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    function automatic logic par_of(input logic [7:0] d, input logic odd);
        return odd ? ~^d : ^d;
    endfunction

    function automatic logic [31:0] entry_of(input logic [7:0] d, input logic ovr,
                                            input logic brk, input logic pe, input logic fe);
        return {20'd0, ovr, brk, pe, fe, d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        @(negedge clk);
        addr = a; rd_en = (a == 1'b0);
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        addr = 1'b0; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] d, input logic bad_par, input logic stop_v,
                           input int low_extra);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (par_en) begin
            rxd = par_of(d, par_odd) ^ bad_par;
            repeat (BIT) @(negedge clk);
        end
        rxd = stop_v;
        repeat (BIT + low_extra) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic cap_tx(output logic [7:0] d, output logic pb, output logic sb,
                          output logic st);
        wait (txd == 1'b0);
        repeat (BIT / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            d[i] = txd;
        end
        pb = 1'b0;
        if (par_en) begin
            repeat (BIT) @(negedge clk);
            pb = txd;
        end
        repeat (BIT) @(negedge clk);
        sb = txd;
    endtask

    task automatic quiet_tx(input string req);
        logic seen;
        seen = 1'b0;
        repeat (BIT * 12) begin
            @(negedge clk);
            if (txd == 1'b0) seen = 1'b1;
        end
        chk(req, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  d, b;
        logic        pb, sb, st, bp;
        logic [7:0]  q [0:17];

        void'($urandom(32'd20241));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 txd idle", {31'd0, txd}, 32'd1);
        rd(1'b1, v); chk("R1 status read", v, 32'd0);
        rd(1'b0, v); chk("R1 data read", v, 32'd0);

        // R2 R3 random transmit frames
        for (int k = 0; k < 6; k++) begin
            par_en = 1'($urandom % 2); par_odd = 1'($urandom % 2);
            b = 8'($urandom);
            wr(b);
            cap_tx(d, pb, sb, st);
            chk("R2 start bit", {31'd0, st}, 32'd0);
            chk("R2 data bits", {24'd0, d}, {24'd0, b});
            chk("R2 stop bit", {31'd0, sb}, 32'd1);
            if (par_en) chk("R3 tx parity", {31'd0, pb}, {31'd0, par_of(b, par_odd)});
        end
        par_en = 1'b0;

        // R4 queue order and full discard
        for (int k = 0; k < 18; k++) q[k] = 8'($urandom);
        @(negedge clk);
        for (int k = 0; k < 18; k++) begin
            addr = 1'b0; wdata = q[k]; wr_en = 1'b1;
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int k = 0; k < 17; k++) begin
            cap_tx(d, pb, sb, st);
            chk("R4 tx order", {24'd0, d}, {24'd0, q[k]});
        end
        quiet_tx("R4 write to full queue dropped");

        // R5 single-word transmit
        fifo_en = 1'b0;
        wr(8'hA5);
        repeat (4) @(negedge clk);
        wr(8'h3C);
        wr(8'hFF);
        cap_tx(d, pb, sb, st); chk("R5 first word", {24'd0, d}, 32'hA5);
        cap_tx(d, pb, sb, st); chk("R5 held word", {24'd0, d}, 32'h3C);
        quiet_tx("R5 write while held dropped");
        fifo_en = 1'b1;

        // R6 R8 random receive with parity modes
        for (int k = 0; k < 10; k++) begin
            par_en = 1'($urandom % 2); par_odd = 1'($urandom % 2);
            b = 8'($urandom);
            bp = par_en && ($urandom % 3 == 0);
            send_rx(b, bp, 1'b1, 0);
            rd(1'b0, v);
            chk(bp ? "R8 parity error entry" : "R6 rx entry", v, entry_of(b, 0, 0, bp, 0));
        end
        par_en = 1'b0;
        rd(1'b0, v); chk("R6 empty read zero", v, 32'd0);

        // R7 status peek does not remove
        par_en = 1'b1; par_odd = 1'b1;
        send_rx(8'h5A, 1'b1, 1'b1, 0);
        rd(1'b1, v); chk("R7 status flags", v, 32'h2);
        rd(1'b0, v); chk("R7 entry still present", v, entry_of(8'h5A, 0, 0, 1, 0));
        par_en = 1'b0;

        // R9 framing error, line held low after stop
        send_rx(8'h81, 1'b0, 1'b0, BIT * 3);
        rd(1'b0, v); chk("R9 framing entry", v, entry_of(8'h81, 0, 0, 0, 1));
        rd(1'b0, v); chk("R9 no phantom after low stop", v, 32'd0);

        // R10 break
        send_rx(8'h00, 1'b0, 1'b0, BIT * 4);
        rd(1'b0, v); chk("R10 break entry", v, 32'h500);
        rd(1'b0, v); chk("R10 single break entry", v, 32'd0);

        // R11 start glitch
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk); rxd = 1'b1;
        repeat (BIT * 12) @(negedge clk);
        rd(1'b1, v); chk("R11 glitch stores nothing", v, 32'd0);
        send_rx(8'hC3, 1'b0, 1'b1, 0);
        rd(1'b0, v); chk("R11 frame after glitch", v, entry_of(8'hC3, 0, 0, 0, 0));

        // R12 overrun in queue mode
        for (int k = 0; k < 17; k++) begin
            q[k] = 8'($urandom);
            send_rx(q[k], 1'b0, 1'b1, 0);
        end
        for (int k = 0; k < 16; k++) begin
            rd(1'b0, v);
            chk("R12 queued entry", v, entry_of(q[k], k == 15, 0, 0, 0));
        end
        rd(1'b0, v); chk("R12 dropped char absent", v, 32'd0);
        send_rx(8'h77, 1'b0, 1'b1, 0);
        rd(1'b0, v); chk("R12 overrun cleared on next", v, entry_of(8'h77, 0, 0, 0, 0));

        // R12 single-word receive
        fifo_en = 1'b0;
        send_rx(8'h12, 1'b0, 1'b1, 0);
        send_rx(8'h34, 1'b0, 1'b1, 0);
        rd(1'b1, v); chk("R12 single overrun status", v, 32'h8);
        rd(1'b0, v); chk("R12 single overrun entry", v, entry_of(8'h12, 1, 0, 0, 0));
        rd(1'b0, v); chk("R12 single holds one", v, 32'd0);
        send_rx(8'h56, 1'b0, 1'b1, 0);
        rd(1'b0, v); chk("R12 single clean next", v, entry_of(8'h56, 0, 0, 0, 0));

        finish_run();
    end
endmodule